// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. Two external request lines and one internal timer request are level-sensitive. The block samples them into a status word that the core can read. A separate non-maskable input is watched for a rising level. Each rise gives a single-cycle take pulse, whatever the mask or the core's interrupt-disable flag says.

Software reaches the block through a two-address window on an 8-bit bus. Address 0 holds a 3-bit disable mask. Address 1 reports which request lines are asserted. On every clock the block works out again whether any unmasked request is pending and whether the core's interrupt-disable flag is clear. From that it drives a maskable request output and a 2-bit index that names the highest-priority pending source. Vector fetch, stacking and the core itself live elsewhere.

Top module: `irq_triage_ctrl`

## Requirements
- R1: A bus write to address 0 keeps only data bits [2:0] as the new mask. Reading address 0 after the write returns those three bits, and bits [7:3] read as zero.
- R2: Reading address 0 returns the current mask in bits [2:0], with zero in every higher bit.
- R3: Reading address 1 returns the sampled request levels: bit 0 is the second external line, bit 1 is the first external line, bit 2 is the timer line, and the higher bits are zero. Each bit follows its line's level one clock after that level is sampled, so a cleared line drops its bit on the next cycle.
- R4: A mask bit of 1 blocks its source. Mask bit 0 gates the second external line, bit 1 the first external line, and bit 2 the timer. `irq_out` is high one clock after at least one unmasked line is sampled high while `cpu_idis` is low.
- R5: While `cpu_idis` is sampled high, `irq_out` is low on the following cycle, no matter which requests are pending.
- R6: When several unmasked requests are pending, the timer wins, then the first external line, then the second. `irq_vec` reads 2 for the timer, 1 for the first external line and 0 for the second, and it is 0 whenever `irq_out` is low.
- R7: `nmi_take` goes high for exactly one cycle, one clock after `nmi_in` is first sampled high following a low sample. A level that is held high gives no further pulse. The mask and `cpu_idis` have no effect on it.
- R8: Under reset the mask and the status are zero, and `irq_out`, `irq_vec` and `nmi_take` are zero.
- R9: A mask write takes effect on `irq_out` in the same cycle as the new mask becomes readable. Masking the only pending source drops the request, and unmasking it raises the request.
- R10: A bus write to address 1 changes neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 1 | Window address: 0 is the mask, 1 is the status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext1_req | input | 1 | First external request line, level-sensitive |
| ext2_req | input | 1 | Second external request line, level-sensitive |
| tmr_req | input | 1 | Timer request line, level-sensitive |
| nmi_in | input | 1 | Non-maskable interrupt level |
| cpu_idis | input | 1 | Interrupt-disable flag from the core |
| irq_out | output | 1 | Maskable interrupt request to the core |
| irq_vec | output | 2 | Index of the selected source |
| nmi_take | output | 1 | Single-cycle pulse taking the non-maskable interrupt |

## Verification
The hardest case to reach is a mask write that lands while all three lines are held high. Here the chosen vector has to step down through the priority order as the higher sources are masked one at a time. The data written at the same time also carries junk in its upper bits. The stimulus table keeps every line asserted and issues successive mask writes with the upper data bits set. It then raises the disable flag on top of the same pending set. After each step it reads both addresses back, so a priority slip or a leak of the upper bits shows at the ports.

// File: rtl/irq_triage_pkg.sv
package irq_triage_pkg;
    localparam int NUM_SRC = 3;
    localparam int IDX_W   = $clog2(NUM_SRC);

    // window addresses
    localparam logic ADDR_MASK = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // source index codes; higher index has higher priority
    typedef enum logic [IDX_W-1:0] {
        SRC_EXT2 = 2'd0,
        SRC_EXT1 = 2'd1,
        SRC_TMR  = 2'd2
    } src_e;
endpackage

// File: rtl/irq_win_regs.sv
module irq_win_regs
    import irq_triage_pkg::*;
#(
    parameter int DW = 8,
    parameter int NS = NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  logic [NS-1:0] status,
    output logic [NS-1:0] mask_q,
    output logic [NS-1:0] mask_d,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [NS-1:0] mask;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && addr == ADDR_MASK) begin
            st_d.mask = wdata[NS-1:0];
        end
        rdata = '0;
        if (addr == ADDR_MASK) begin
            rdata[NS-1:0] = st_q.mask;
        end else begin
            rdata[NS-1:0] = status;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
    assign mask_d = st_d.mask;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NS = 3,
    parameter int IW = $clog2(NS)
) (
    input  logic [NS-1:0] pend,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |pend;
        idx = '0;
        // ascending scan: the last hit, the highest index, wins
        for (int i = 0; i < NS; i++) begin
            if (pend[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/nmi_rise_det.sv
module nmi_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic pulse
);
    typedef struct packed {
        logic lvl;
        logic take;
    } nmi_t;

    nmi_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lvl  = lvl_in;
        st_d.take = lvl_in & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.take;
endmodule

// File: rtl/irq_triage_ctrl.sv
module irq_triage_ctrl
    import irq_triage_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             ext1_req,
    input  logic             ext2_req,
    input  logic             tmr_req,
    input  logic             nmi_in,
    input  logic             cpu_idis,
    output logic             irq_out,
    output logic [IDX_W-1:0] irq_vec,
    output logic             nmi_take
);
    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic               irq;
        logic [IDX_W-1:0]   vec;
    } core_t;

    core_t st_d, st_q;

    logic [NUM_SRC-1:0] mask_q, mask_d, stat_q, line_in;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    // bit order is fixed: second external line lowest, timer highest
    assign line_in = {tmr_req, ext1_req, ext2_req};
    assign stat_q  = st_q.req;

    irq_win_regs #(.DW(DW), .NS(NUM_SRC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .status (stat_q),
        .mask_q (mask_q),
        .mask_d (mask_d),
        .rdata  (bus_rdata)
    );

    irq_prio_pick #(.NS(NUM_SRC), .IW(IDX_W)) u_pick (
        .pend (line_in & ~mask_d),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    nmi_rise_det u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (nmi_in),
        .pulse  (nmi_take)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = line_in;
        st_d.irq = pick_any & ~cpu_idis;
        st_d.vec = st_d.irq ? pick_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.irq;
    assign irq_vec = st_q.vec;
endmodule

// File: rtl/irq_triage_chk.sv
module irq_triage_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          ext1_req,
    input logic          ext2_req,
    input logic          tmr_req,
    input logic          nmi_in,
    input logic          cpu_idis,
    input logic          irq_out,
    input logic [1:0]    irq_vec,
    input logic          nmi_take,
    input logic [2:0]    mask,
    input logic [2:0]    status
);
    logic [2:0] unm;
    assign unm = status & ~mask;

    p_mask_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == 1'b0) |-> mask == $past(bus_wdata[2:0]));

    p_stat_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status == $past({tmr_req, ext1_req, ext2_req}));

    p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> unm != 3'b000);

    p_idis_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_idis) |-> !irq_out);

    p_vec_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (((unm >> irq_vec) & 3'b001) != 3'b000));

    p_vec_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((unm >> irq_vec) >> 1) == 3'b000);

    p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> irq_vec == 2'd0);

    p_nmi_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> !nmi_take);

    p_nmi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |-> $past(nmi_in));
endmodule

bind irq_triage_ctrl irq_triage_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ext1_req  (ext1_req),
    .ext2_req  (ext2_req),
    .tmr_req   (tmr_req),
    .nmi_in    (nmi_in),
    .cpu_idis  (cpu_idis),
    .irq_out   (irq_out),
    .irq_vec   (irq_vec),
    .nmi_take  (nmi_take),
    .mask      (mask_q),
    .status    (stat_q)
);

// File: tb/sim_irq_triage_ctrl.sv
module sim_irq_triage_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext1_req = 1'b0, ext2_req = 1'b0, tmr_req = 1'b0;
    logic       nmi_in = 1'b0, cpu_idis = 1'b0;
    logic       irq_out, nmi_take;
    logic [1:0] irq_vec;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_triage_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext1_req(ext1_req),
        .ext2_req(ext2_req), .tmr_req(tmr_req), .nmi_in(nmi_in),
        .cpu_idis(cpu_idis), .irq_out(irq_out), .irq_vec(irq_vec),
        .nmi_take(nmi_take)
    );

    // vector: we, addr, wdata[8], lines{tmr,ext1,ext2}[3], idis,
    //         exp_irq, exp_vec[2], exp_stat[3], exp_mask[3]  = 23 bits
    localparam int NV = 10;
    localparam logic [22:0] TBL [NV] = '{
        {1'b0,1'b0,8'h00,3'b001,1'b0, 1'b1,2'd0,3'b001,3'b000}, // R4 ext2 alone
        {1'b0,1'b0,8'h00,3'b011,1'b0, 1'b1,2'd1,3'b011,3'b000}, // R6 ext1 over ext2
        {1'b0,1'b0,8'h00,3'b111,1'b0, 1'b1,2'd2,3'b111,3'b000}, // R6 timer first
        {1'b1,1'b0,8'hFC,3'b111,1'b0, 1'b1,2'd1,3'b111,3'b100}, // R1 upper bits dropped
        {1'b1,1'b0,8'hFE,3'b111,1'b0, 1'b1,2'd0,3'b111,3'b110}, // R4 only ext2 open
        {1'b0,1'b0,8'h00,3'b111,1'b1, 1'b0,2'd0,3'b111,3'b110}, // R5 disable flag
        {1'b1,1'b0,8'h07,3'b111,1'b0, 1'b0,2'd0,3'b111,3'b111}, // R9 mask all
        {1'b1,1'b0,8'h00,3'b100,1'b0, 1'b1,2'd2,3'b100,3'b000}, // R9 unmask raises
        {1'b0,1'b0,8'h00,3'b000,1'b0, 1'b0,2'd0,3'b000,3'b000}, // R3 clear drops
        {1'b1,1'b1,8'h07,3'b010,1'b0, 1'b1,2'd1,3'b010,3'b000}  // R10 write to addr 1
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // R8 reset state
        #20;
        chk("R8 irq", {7'd0, irq_out}, 8'd0);
        chk("R8 vec", {6'd0, irq_vec}, 8'd0);
        chk("R8 nmi", {7'd0, nmi_take}, 8'd0);
        bus_addr = 1'b0; #1;
        chk("R8 mask", bus_rdata, 8'h00);
        bus_addr = 1'b1; #1;
        chk("R8 status", bus_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            {bus_we, bus_addr, bus_wdata, tmr_req, ext1_req, ext2_req, cpu_idis} = TBL[i][22:9];
            tick();
            bus_we = 1'b0;
            chk("R4/R5/R9 irq", {7'd0, irq_out}, {7'd0, TBL[i][8]});
            chk("R6 vec", {6'd0, irq_vec}, {6'd0, TBL[i][7:6]});
            bus_addr = 1'b1; #1;
            chk("R3/R10 status", bus_rdata, {5'd0, TBL[i][5:3]});
            bus_addr = 1'b0; #1;
            chk("R1/R2 mask", bus_rdata, {5'd0, TBL[i][2:0]});
        end

        // R7 nmi: rise gives one pulse, held gives none, mask and disable ignored
        bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'hFF; cpu_idis = 1'b1;
        {tmr_req, ext1_req, ext2_req} = 3'b000;
        tick();
        bus_we = 1'b0;
        chk("R2 upper zero", bus_rdata, 8'h07);
        nmi_in = 1'b1;
        tick();
        chk("R7 pulse", {7'd0, nmi_take}, 8'd1);
        tick();
        chk("R7 pulse ends", {7'd0, nmi_take}, 8'd0);
        tick();
        chk("R7 held quiet", {7'd0, nmi_take}, 8'd0);
        nmi_in = 1'b0;
        tick();
        chk("R7 fall quiet", {7'd0, nmi_take}, 8'd0);
        nmi_in = 1'b1;
        tick();
        chk("R7 second rise", {7'd0, nmi_take}, 8'd1);
        chk("R5 irq low", {7'd0, irq_out}, 8'd0);
        nmi_in = 1'b0;
        tick();

        // R3 status bit one cycle after line change, during the same window
        ext1_req = 1'b1;
        bus_addr = 1'b1; #1;
        chk("R3 not yet", bus_rdata, 8'h00);
        tick();
        #1;
        chk("R3 sampled", bus_rdata, 8'h02);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule